// File: doc/BRIEF.md
# DMA Channel Address Sequencer

This block generates the source and destination addresses of one DMA channel and holds the channel's 16-bit control word. After software loads the two 32-bit addresses and the control word through a small register port, each transfer beat reported on `beat_done` moves each address by a signed step. The step size comes from the transfer width: 1 for a byte and 2 for a word. Each address has its own two-bit mode in the control word, which chooses whether that address stays fixed, counts up or counts down.

When the channel runs in single-address mode, an external device that is served by an acknowledge strobe takes one side of the transfer. The address for that side is then frozen, whatever its mode field says. The control word also carries a four-bit transfer-request selector. That field is locked while the channel enable bit is set. A standby input clears the mode fields and the request selector. A reserved mode encoding behaves like a fixed address and raises a sticky error bit that software can read.

Top module: `dma_addr_seq`

## Requirements
- R1: After reset, both addresses, the whole control word and the error bit are zero, and `chan_en` and `req_src` are zero.
- R2: The read port returns the source address at offset 0, the destination address at offset 1, the control word zero-extended at offset 2, and the error bit in bit 0 at offset 3. Control bits 7:1 read back exactly as written.
- R3: Control bit 0 is the enable. Bits 15:14 are the destination mode and bits 13:12 the source mode. Mode 00 keeps the address, 01 adds the step, and 10 subtracts it. The step is 1 when `size_word`=0 and 2 when `size_word`=1.
- R4: Address arithmetic wraps modulo 2^32.
- R5: An address changes only on a cycle with `beat_done`=1 while the enable is 1, or through a register write while the enable is 0.
- R6: With `single_addr`=1 and `mem_to_dev`=1, a beat leaves the destination address unchanged for every destination mode.
- R7: With `single_addr`=1 and `dev_to_mem`=1, a beat leaves the source address unchanged for every source mode. With `single_addr`=0, both direction flags have no effect.
- R8: Bits 11:8 select the transfer-request source and drive `req_src`. While the enable is 1, writes leave this field unchanged but still update every other control bit.
- R9: Writes to either address register are ignored while the enable is 1.
- R10: A cycle with `standby`=1 clears bits 15:8 of the control word and the error bit. It keeps the enable, bits 7:1 and both addresses.
- R11: Mode 11 holds the address. A beat that uses mode 11 on a side that is not frozen sets the error bit, which stays set until reset or standby.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| standby | input | 1 | Standby entry, clears mode and request fields |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register offset (0 src, 1 dst, 2 control, 3 status) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from `reg_addr` |
| beat_done | input | 1 | One transfer beat completed |
| size_word | input | 1 | 1 = word transfer, 0 = byte transfer |
| single_addr | input | 1 | Single-address mode |
| mem_to_dev | input | 1 | Memory to acknowledge-driven device |
| dev_to_mem | input | 1 | Acknowledge-driven device to memory |
| chan_en | output | 1 | Control enable bit |
| req_src | output | 4 | Transfer-request source selector |
| src_addr | output | 32 | Current source address |
| dst_addr | output | 32 | Current destination address |

## Verification
The main sweep applies one beat to every pair of source and destination modes, including the reserved code. Each pair is tried with both transfer sizes, with single-address mode on and off, and with no direction flag or either one set. The start addresses sit at the top and bottom of the 32-bit range. This separates increment from decrement, byte steps from word steps, and wrap from saturation. It also shows which side a direction flag freezes, and that the flags do nothing outside single-address mode. Directed sequences cover the request-field lock, address writes while enabled, stickiness of the error bit, and the fields that standby clears compared with those it keeps.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

   typedef enum logic [1:0] {
      AM_FIXED = 2'b00,
      AM_INC   = 2'b01,
      AM_DEC   = 2'b10,
      AM_RSVD  = 2'b11
   } addr_mode_e;

   localparam int CTRL_W  = 16;
   localparam int DM_LSB  = 14;
   localparam int SM_LSB  = 12;
   localparam int RQ_LSB  = 8;
   localparam int RQ_W    = 4;
   localparam int EN_BIT  = 0;

   localparam logic [1:0] RA_SRC  = 2'd0;
   localparam logic [1:0] RA_DST  = 2'd1;
   localparam logic [1:0] RA_CTRL = 2'd2;
   localparam logic [1:0] RA_STAT = 2'd3;

   localparam int SIDE_SRC = 0;
   localparam int SIDE_DST = 1;
   localparam int N_SIDES  = 2;

endpackage

// File: rtl/dma_ctrl_reg.sv
module dma_ctrl_reg
   import dma_seq_pkg::*;
#(
   parameter int W = CTRL_W
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            standby,
   input  logic            wr_en,
   input  logic [W-1:0]    wr_data,
   output logic [W-1:0]    ctrl_q,
   output logic            enable,
   output addr_mode_e      dst_mode,
   output addr_mode_e      src_mode,
   output logic [RQ_W-1:0] rq_sel
);

   localparam int CLR_LSB = RQ_LSB;
   localparam int CLR_W   = W - RQ_LSB;

   if (W < DM_LSB + 2) begin : g_bad_width
      $error("dma_ctrl_reg: control width too small for field layout");
   end

   logic [W-1:0] ctrl_d;

   always_comb begin
      ctrl_d = ctrl_q;
      if (standby) begin
         ctrl_d[CLR_LSB +: CLR_W] = '0;
      end else if (wr_en) begin
         ctrl_d = wr_data;
         if (ctrl_q[EN_BIT]) begin
            ctrl_d[RQ_LSB +: RQ_W] = ctrl_q[RQ_LSB +: RQ_W];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ctrl_q <= '0;
      else        ctrl_q <= ctrl_d;
   end

   assign enable   = ctrl_q[EN_BIT];
   assign dst_mode = addr_mode_e'(ctrl_q[DM_LSB +: 2]);
   assign src_mode = addr_mode_e'(ctrl_q[SM_LSB +: 2]);
   assign rq_sel   = ctrl_q[RQ_LSB +: RQ_W];

   AST_RQ_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && !standby) |=> $stable(rq_sel)); // R8

   AST_STBY_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      standby |=> (dst_mode == AM_FIXED && src_mode == AM_FIXED && rq_sel == '0)); // R10

   AST_STBY_KEEPS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      standby |=> $stable(enable)); // R10

endmodule

// File: rtl/dma_addr_side.sv
module dma_addr_side
   import dma_seq_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int WORD_STEP = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_data,
   input  logic              beat,
   input  logic              hold,
   input  logic              size_word,
   input  addr_mode_e        mode,
   output logic [ADDR_W-1:0] addr_q,
   output logic              rsvd_hit
);

   if (ADDR_W < 2) begin : g_bad_addr
      $error("dma_addr_side: address width must be at least 2");
   end
   if (WORD_STEP < 1) begin : g_bad_step
      $error("dma_addr_side: word step must be positive");
   end

   localparam logic [ADDR_W-1:0] STEP_B = ADDR_W'(1);
   localparam logic [ADDR_W-1:0] STEP_W = ADDR_W'(WORD_STEP);

   logic [ADDR_W-1:0] step;
   logic [ADDR_W-1:0] addr_d;
   logic              live;

   assign step = size_word ? STEP_W : STEP_B;
   assign live = beat && !hold;

   always_comb begin
      addr_d = addr_q;
      if (wr_en) begin
         addr_d = wr_data;
      end else if (live) begin
         unique case (mode)
            AM_INC:  addr_d = addr_q + step;
            AM_DEC:  addr_d = addr_q - step;
            default: addr_d = addr_q;
         endcase
      end
   end

   assign rsvd_hit = live && (mode == AM_RSVD);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) addr_q <= '0;
      else        addr_q <= addr_d;
   end

   AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!beat && !wr_en) |=> $stable(addr_q)); // R5

   AST_INC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (beat && !hold && !wr_en && mode == AM_INC && !size_word)
      |=> addr_q == $past(addr_q) + STEP_B); // R3

   AST_DEC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (beat && !hold && !wr_en && mode == AM_DEC && size_word)
      |=> addr_q == $past(addr_q) - STEP_W); // R3

   AST_FROZEN_SIDE: assert property (@(posedge clk) disable iff (!rst_n)
      (beat && hold && !wr_en) |=> $stable(addr_q)); // R6

   AST_RSVD_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (beat && !wr_en && mode == AM_RSVD) |=> $stable(addr_q)); // R11

endmodule

// File: rtl/dma_addr_seq.sv
module dma_addr_seq
   import dma_seq_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int WORD_STEP = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              standby,
   input  logic              reg_wr,
   input  logic [1:0]        reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   input  logic              beat_done,
   input  logic              size_word,
   input  logic              single_addr,
   input  logic              mem_to_dev,
   input  logic              dev_to_mem,
   output logic              chan_en,
   output logic [3:0]        req_src,
   output logic [ADDR_W-1:0] src_addr,
   output logic [ADDR_W-1:0] dst_addr
);

   if (ADDR_W != 32) begin : g_bad_bus
      $error("dma_addr_seq: register port assumes 32-bit addresses");
   end

   logic [CTRL_W-1:0] ctrl_q;
   addr_mode_e        dst_mode;
   addr_mode_e        src_mode;
   logic [RQ_W-1:0]   rq_sel;
   logic              ctrl_wr;
   logic              beat_q;
   logic              err_q;

   addr_mode_e        side_mode [N_SIDES];
   logic              side_hold [N_SIDES];
   logic              side_wr   [N_SIDES];
   logic [ADDR_W-1:0] side_addr [N_SIDES];
   logic              side_rsvd [N_SIDES];

   assign ctrl_wr = reg_wr && (reg_addr == RA_CTRL);

   dma_ctrl_reg #(.W(CTRL_W)) i_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .standby  (standby),
      .wr_en    (ctrl_wr),
      .wr_data  (reg_wdata[CTRL_W-1:0]),
      .ctrl_q   (ctrl_q),
      .enable   (chan_en),
      .dst_mode (dst_mode),
      .src_mode (src_mode),
      .rq_sel   (rq_sel)
   );

   assign req_src = rq_sel;
   assign beat_q  = beat_done && chan_en;

   assign side_mode[SIDE_SRC] = src_mode;
   assign side_mode[SIDE_DST] = dst_mode;
   assign side_hold[SIDE_SRC] = single_addr && dev_to_mem;
   assign side_hold[SIDE_DST] = single_addr && mem_to_dev;
   assign side_wr[SIDE_SRC]   = reg_wr && !chan_en && (reg_addr == RA_SRC);
   assign side_wr[SIDE_DST]   = reg_wr && !chan_en && (reg_addr == RA_DST);

   for (genvar s = 0; s < N_SIDES; s++) begin : g_side
      dma_addr_side #(.ADDR_W(ADDR_W), .WORD_STEP(WORD_STEP)) i_side (
         .clk       (clk),
         .rst_n     (rst_n),
         .wr_en     (side_wr[s]),
         .wr_data   (reg_wdata[ADDR_W-1:0]),
         .beat      (beat_q),
         .hold      (side_hold[s]),
         .size_word (size_word),
         .mode      (side_mode[s]),
         .addr_q    (side_addr[s]),
         .rsvd_hit  (side_rsvd[s])
      );
   end

   assign src_addr = side_addr[SIDE_SRC];
   assign dst_addr = side_addr[SIDE_DST];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                    err_q <= 1'b0;
      else if (standby)                              err_q <= 1'b0;
      else if (side_rsvd[SIDE_SRC] || side_rsvd[SIDE_DST]) err_q <= 1'b1;
   end

   always_comb begin
      unique case (reg_addr)
         RA_SRC:  reg_rdata = src_addr;
         RA_DST:  reg_rdata = dst_addr;
         RA_CTRL: reg_rdata = {{(32-CTRL_W){1'b0}}, ctrl_q};
         default: reg_rdata = {31'b0, err_q};
      endcase
   end

   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (err_q && !standby) |=> err_q); // R11

   AST_ADDR_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      (chan_en && !beat_done) |=> ($stable(src_addr) && $stable(dst_addr))); // R9

   AST_DISABLED_NO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (!chan_en && !reg_wr) |=> ($stable(src_addr) && $stable(dst_addr))); // R5

   AST_FLAGS_INERT: assert property (@(posedge clk) disable iff (!rst_n)
      (beat_q && !single_addr && src_mode == AM_INC && !reg_wr)
      |=> src_addr != $past(src_addr)); // R7

endmodule

// File: tb/test_dma_addr_seq.sv
`timescale 1ns/1ps
module test_dma_addr_seq;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        standby = 1'b0;
   logic        reg_wr = 1'b0;
   logic [1:0]  reg_addr = 2'd0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        beat_done = 1'b0;
   logic        size_word = 1'b0;
   logic        single_addr = 1'b0;
   logic        mem_to_dev = 1'b0;
   logic        dev_to_mem = 1'b0;
   logic        chan_en;
   logic [3:0]  req_src;
   logic [31:0] src_addr;
   logic [31:0] dst_addr;

   int n_checks = 0;
   int n_fails  = 0;
   bit done     = 1'b0;

   always #4 clk = ~clk;

   dma_addr_seq i_dma_addr_seq (
      .clk(clk), .rst_n(rst_n), .standby(standby),
      .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .beat_done(beat_done), .size_word(size_word),
      .single_addr(single_addr), .mem_to_dev(mem_to_dev), .dev_to_mem(dev_to_mem),
      .chan_en(chan_en), .req_src(req_src), .src_addr(src_addr), .dst_addr(dst_addr)
   );

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_checks++;
      if (got !== exp) begin
         n_fails++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   task automatic beat();
      @(negedge clk);
      beat_done = 1'b1;
      @(negedge clk);
      beat_done = 1'b0;
   endtask

   task automatic stby();
      @(negedge clk);
      standby = 1'b1;
      @(negedge clk);
      standby = 1'b0;
   endtask

   function automatic logic [31:0] next_addr(input logic [31:0] a, input int m,
                                             input bit frozen, input bit wsz);
      logic [31:0] st;
      st = wsz ? 32'd2 : 32'd1;
      if (frozen) return a;
      if (m == 1) return a + st;
      if (m == 2) return a - st;
      return a;
   endfunction

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
   endtask

   initial begin
      logic [31:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      rd(2'd0, v); chk("R1 src", v, 32'h0);
      rd(2'd1, v); chk("R1 dst", v, 32'h0);
      rd(2'd2, v); chk("R1 ctrl", v, 32'h0);
      rd(2'd3, v); chk("R1 err", v, 32'h0);
      chk("R1 chan_en/req_src", {27'b0, chan_en, req_src}, 32'h0);

      // R2 register map and plain bits
      wr(2'd2, 32'hFFFF_00FE); rd(2'd2, v); chk("R2 ctrl readback", v, 32'h0000_00FE);
      wr(2'd0, 32'h1234_5678); rd(2'd0, v); chk("R2 src readback", v, 32'h1234_5678);
      wr(2'd1, 32'h9ABC_DEF0); rd(2'd1, v); chk("R2 dst readback", v, 32'h9ABC_DEF0);

      // R5 beat while disabled does nothing
      wr(2'd2, 32'h0000_5000); beat();
      rd(2'd0, v); chk("R5 src no step when disabled", v, 32'h1234_5678);
      rd(2'd1, v); chk("R5 dst no step when disabled", v, 32'h9ABC_DEF0);

      // R8 request field locked while enabled
      wr(2'd2, 32'h0000_0301);
      chk("R8 req_src set while disabled", {28'b0, req_src}, 32'h3);
      wr(2'd2, 32'h0000_5A01); rd(2'd2, v); chk("R8 lock keeps other bits", v, 32'h0000_5301);
      // R9 address write ignored while enabled
      wr(2'd0, 32'hDEAD_BEEF); rd(2'd0, v); chk("R9 src write locked", v, 32'h1234_5678);
      wr(2'd1, 32'hDEAD_BEEF); rd(2'd1, v); chk("R9 dst write locked", v, 32'h9ABC_DEF0);
      wr(2'd2, 32'h0000_0A00); rd(2'd2, v); chk("R8 disabling write still locked", v, 32'h0000_0300);
      wr(2'd2, 32'h0000_0A00); rd(2'd2, v); chk("R8 unlocked write", v, 32'h0000_0A00);

      // R11 sticky error
      wr(2'd2, 32'h0000_3001); beat();
      rd(2'd3, v); chk("R11 err set", v, 32'h1);
      rd(2'd0, v); chk("R11 reserved holds src", v, 32'h1234_5678);
      wr(2'd2, 32'h0000_0001); beat();
      rd(2'd3, v); chk("R11 err sticky", v, 32'h1);

      // R10 standby clears modes, request and error, keeps rest
      wr(2'd2, 32'h0000_F7F1);
      stby();
      rd(2'd2, v); chk("R10 ctrl after standby", v, 32'h0000_00F1);
      rd(2'd3, v); chk("R10 err cleared", v, 32'h0);
      rd(2'd0, v); chk("R10 src kept", v, 32'h1234_5678);

      // R3 R4 R6 R7 R11 sweep
      for (int dm = 0; dm < 4; dm++)
         for (int sm = 0; sm < 4; sm++)
            for (int sz = 0; sz < 2; sz++)
               for (int sa = 0; sa < 2; sa++)
                  for (int dir = 0; dir < 3; dir++) begin
                     logic [31:0] s0, d0, es, ed, ee;
                     bit fs, fd;
                     int k;
                     k  = dm + sm + sz + sa + dir;
                     s0 = 32'hFFFF_FFFF - 32'(k % 3);
                     d0 = 32'(k % 3);
                     fd = (sa == 1) && (dir == 1);
                     fs = (sa == 1) && (dir == 2);
                     stby();
                     wr(2'd2, 32'h0);
                     wr(2'd0, s0);
                     wr(2'd1, d0);
                     wr(2'd2, 32'((dm << 14) | (sm << 12) | 1));
                     @(negedge clk);
                     size_word = sz[0]; single_addr = sa[0];
                     mem_to_dev = (dir == 1); dev_to_mem = (dir == 2);
                     beat();
                     es = next_addr(s0, sm, fs, sz[0]);
                     ed = next_addr(d0, dm, fd, sz[0]);
                     ee = ((!fs && sm == 3) || (!fd && dm == 3)) ? 32'h1 : 32'h0;
                     rd(2'd0, v); chk($sformatf("R3/R4/R7 src dm%0d sm%0d sz%0d sa%0d dir%0d", dm, sm, sz, sa, dir), v, es);
                     rd(2'd1, v); chk($sformatf("R3/R4/R6 dst dm%0d sm%0d sz%0d sa%0d dir%0d", dm, sm, sz, sa, dir), v, ed);
                     rd(2'd3, v); chk($sformatf("R11 err dm%0d sm%0d sa%0d dir%0d", dm, sm, sa, dir), v, ee);
                  end

      done = 1'b1;
      summary();
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fails++;
         $display("FAIL R5 watchdog: got timeout expected completion");
         summary();
         $finish;
      end
   end

endmodule